// File: doc/BRIEF.md
# Serial Controller Register and Flag Block

This block is the software-visible register file of a serial controller that has a receive FIFO. It sits on a simple single-cycle memory-mapped bus with a strobe, a write flag, a 6-bit byte offset and 8-bit data. It holds the mode, bit-rate, control, FIFO-control and port registers. It also keeps five status flags: transmit done, transmit buffer empty, line break, receive level reached and data ready. The block drives a transmit interrupt line and a receive interrupt line.

The FIFO storage, the baud generator and the shift registers live outside the block. Hardware raises flags through a one-hot-per-bit `flag_set` vector. Software lowers a flag by writing a zero to its status bit; writing a one to a status bit leaves that flag alone.

A byte written to the transmit data offset leaves the block on a valid/ready stream. `tx_valid` rises in the cycle after the write and stays high with `tx_data` stable until the serializer accepts it with `tx_ready`. A second write while a byte is still pending replaces that byte; software is expected to wait for transmit-buffer-empty before it writes again.

Top module: `serial_ctrl_regs`

## Requirements
- R1: After reset, offset 0x00 reads 0x00, 0x04 reads 0xFF, 0x08 reads 0x20, 0x10 reads 0x60, 0x18 reads 0x00 and 0x20 reads 0x00; `tx_valid`, `tx_irq` and `rx_irq` are low.
- R2: A write stores its data ANDed with 0x7B at offset 0x00 (mode), 0xFA at 0x08 (control) and 0xF3 at 0x20 (port). It stores the full byte at 0x04 (bit-rate) and 0x18 (FIFO control). Each register reads back at its own offset from the next cycle.
- R3: Offset 0x10 reads the flags at bit 6 transmit-done, bit 5 transmit-empty, bit 4 break, bit 1 receive-level and bit 0 data-ready, with all other bits 0. A write there clears every one of those flags whose written bit is 0 and leaves every flag whose written bit is 1.
- R4: `flag_set` bit 0 (data-ready), 1 (receive-level), 2 (break), 3 (transmit-empty) and 4 (transmit-done) sets its flag in the next cycle. This takes priority over a software clear in the same cycle.
- R5: A write to 0x0C clears transmit-empty and raises `tx_valid` with the byte on `tx_data` in the next cycle. `tx_valid` and `tx_data` hold until a cycle with `tx_ready` high. A new write while a byte is pending replaces it. Offset 0x0C reads the last byte written.
- R6: A control write with bit 5 at 0 sets transmit-done. `tx_irq` follows control bit 7 from the next cycle. A control write with bit 6 at 0 lowers `rx_irq`.
- R7: `rx_irq` rises the cycle after a `flag_set` bit 1 pulse when control bit 6 is 1, and stays low for such a pulse when bit 6 is 0. A status write with bit 1 or bit 0 at 0 lowers it, unless `flag_set` bit 1 is high in that same cycle.
- R8: FIFO-control bits 7:6 select `rx_trig_level`: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14. A FIFO-control write with bit 1 at 1 pulses `rx_flush` high in that write cycle.
- R9: A read of 0x14 returns `rx_data` and pulses `rx_pop` in that cycle only when `rx_count` is nonzero. A read of 0x1C returns `rx_count`.
- R10: Offset 0x24 and every undefined offset read 0x00. Writes to them change no register, flag or output, and reads of them give no `rx_pop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| flag_set | input | 5 | Hardware flag raise, bit order DR, RDF, BRK, TDE, TEND |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ready | input | 1 | Serializer accepts the byte |
| tx_data | output | 8 | Transmit byte |
| rx_data | input | 8 | Head byte of the receive FIFO |
| rx_count | input | CNT_W | Bytes held in the receive FIFO |
| rx_pop | output | 1 | Remove the head byte from the receive FIFO |
| rx_flush | output | 1 | Empty the receive FIFO |
| rx_trig_level | output | 5 | Receive trigger level in bytes |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The assertions assume that every bus access lasts exactly one cycle. They also assume that `rx_count` gives the true FIFO occupancy, and that `flag_set` and `tx_ready` may take any value in any cycle, including during a status write. The stimulus changes inputs only on the falling clock edge and issues one access per cycle. It deliberately lines up `flag_set` pulses with status writes that clear the same flag, so that the priority rule is exercised inside those assumptions.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int NFLAG  = 5;

  localparam logic [ADDR_W-1:0] OFF_MODE  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_RATE  = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_TXD   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_RXD   = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_FCTL  = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_RCNT  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_PORT  = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_LSTAT = 6'h24;

  localparam logic [DATA_W-1:0] MASK_MODE = 8'h7B;
  localparam logic [DATA_W-1:0] MASK_CTRL = 8'hFA;
  localparam logic [DATA_W-1:0] MASK_PORT = 8'hF3;

  localparam logic [DATA_W-1:0] RST_RATE = 8'hFF;
  localparam logic [DATA_W-1:0] RST_CTRL = 8'h20;

  // flag vector index
  localparam int FL_DR   = 0;
  localparam int FL_RDF  = 1;
  localparam int FL_BRK  = 2;
  localparam int FL_TDE  = 3;
  localparam int FL_TEND = 4;
  localparam logic [NFLAG-1:0] RST_FLAGS = 5'b11000;

  // control / FIFO-control bit positions
  localparam int CTRL_TXE   = 5;
  localparam int CTRL_RIE   = 6;
  localparam int CTRL_TIE   = 7;
  localparam int FCTL_FLUSH = 1;

  // status-register bit position of each flag
  function automatic int flag_pos(input int idx);
    case (idx)
      FL_DR:   return 0;
      FL_RDF:  return 1;
      FL_BRK:  return 4;
      FL_TDE:  return 5;
      default: return 6;
    endcase
  endfunction

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/sreg_flags.sv
module sreg_flags #(
  parameter int               NF  = 5,
  parameter logic [NF-1:0]    RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] hw_set,
  input  logic [NF-1:0] sw_set,
  input  logic [NF-1:0] sw_clr,
  output logic [NF-1:0] q
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q[i] <= RST[i];
      else if (hw_set[i]) q[i] <= 1'b1;
      else if (sw_set[i]) q[i] <= 1'b1;
      else if (sw_clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sreg_tx.sv
module sreg_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= load_data;
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_ctrl_regs.sv
module serial_ctrl_regs
  import sreg_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NFLAG-1:0]  flag_set,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [CNT_W-1:0]  rx_count,
  output logic              rx_pop,
  output logic              rx_flush,
  output logic [4:0]        rx_trig_level,
  output logic              tx_irq,
  output logic              rx_irq
);
  logic wr, rd;
  logic [DATA_W-1:0] mode_q, rate_q, ctrl_q, fctl_q, port_q, stat_rd;
  logic [NFLAG-1:0]  flag_q, sw_set, sw_clr;
  logic              wr_stat, wr_ctrl, wr_txd, rx_drop;

  assign wr      = bus_en &  bus_we;
  assign rd      = bus_en & ~bus_we;
  assign wr_stat = wr && bus_addr == OFF_STAT;
  assign wr_ctrl = wr && bus_addr == OFF_CTRL;
  assign wr_txd  = wr && bus_addr == OFF_TXD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      rate_q <= RST_RATE;
      ctrl_q <= RST_CTRL;
      fctl_q <= '0;
      port_q <= '0;
    end else if (wr) begin
      case (bus_addr)
        OFF_MODE: mode_q <= bus_wdata & MASK_MODE;
        OFF_RATE: rate_q <= bus_wdata;
        OFF_CTRL: ctrl_q <= bus_wdata & MASK_CTRL;
        OFF_FCTL: fctl_q <= bus_wdata;
        OFF_PORT: port_q <= bus_wdata & MASK_PORT;
        default:  ;
      endcase
    end
  end

  // software set / clear per flag
  always_comb begin
    sw_set = '0;
    sw_clr = '0;
    for (int i = 0; i < NFLAG; i++)
      sw_clr[i] = wr_stat & ~bus_wdata[flag_pos(i)];
    sw_set[FL_TEND] = wr_ctrl & ~bus_wdata[CTRL_TXE];
    sw_clr[FL_TDE]  = sw_clr[FL_TDE] | wr_txd;
  end

  sreg_flags #(.NF(NFLAG), .RST(RST_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .hw_set(flag_set),
    .sw_set(sw_set),
    .sw_clr(sw_clr),
    .q     (flag_q)
  );

  sreg_tx #(.DW(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_txd),
    .load_data(bus_wdata),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  // receive interrupt: hardware raise wins over any software drop
  assign rx_drop = (wr_stat & ~(bus_wdata[flag_pos(FL_RDF)] & bus_wdata[flag_pos(FL_DR)]))
                 | (wr_ctrl & ~bus_wdata[CTRL_RIE]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               rx_irq <= 1'b0;
    else if (flag_set[FL_RDF] && ctrl_q[CTRL_RIE]) rx_irq <= 1'b1;
    else if (rx_drop)                         rx_irq <= 1'b0;
  end

  assign tx_irq        = ctrl_q[CTRL_TIE];
  assign rx_trig_level = trig_level(fctl_q[7:6]);
  assign rx_flush      = wr && bus_addr == OFF_FCTL && bus_wdata[FCTL_FLUSH];
  assign rx_pop        = rd && bus_addr == OFF_RXD && rx_count != '0;

  always_comb begin
    stat_rd = '0;
    for (int i = 0; i < NFLAG; i++)
      stat_rd[flag_pos(i)] = flag_q[i];
  end

  always_comb begin
    case (bus_addr)
      OFF_MODE: bus_rdata = mode_q;
      OFF_RATE: bus_rdata = rate_q;
      OFF_CTRL: bus_rdata = ctrl_q;
      OFF_TXD:  bus_rdata = tx_data;
      OFF_STAT: bus_rdata = stat_rd;
      OFF_RXD:  bus_rdata = rx_data;
      OFF_FCTL: bus_rdata = fctl_q;
      OFF_RCNT: bus_rdata = DATA_W'(rx_count);
      OFF_PORT: bus_rdata = port_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sreg_chk.sv
module sreg_chk
  import sreg_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NFLAG-1:0]  flag_set,
  input logic [NFLAG-1:0]  flags,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              rx_irq,
  input logic              tx_irq,
  input logic              rx_pop,
  input logic [CNT_W-1:0]  rx_count
);
  logic st_wr, tx_wr, ct_wr;
  assign st_wr = bus_en && bus_we && bus_addr == OFF_STAT;
  assign tx_wr = bus_en && bus_we && bus_addr == OFF_TXD;
  assign ct_wr = bus_en && bus_we && bus_addr == OFF_CTRL;

  AST_STAT_ONES_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && bus_wdata == 8'hFF && flag_set == '0) |=> $stable(flags)); // R3

  AST_STAT_ZERO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && bus_wdata == 8'h00 && flag_set == '0) |=> flags == '0); // R3

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_set) |=> ((flags & $past(flag_set)) == $past(flag_set))); // R4

  AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> (tx_valid && tx_data == $past(bus_wdata)
               && (!flags[FL_TDE] || $past(flag_set[FL_TDE])))); // R5

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_wr) |=> (tx_valid && $stable(tx_data))); // R5

  AST_TXIRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ct_wr |=> tx_irq == $past(bus_wdata[CTRL_TIE])); // R6

  AST_RXIRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && bus_wdata[1:0] != 2'b11 && !flag_set[FL_RDF]) |=> !rx_irq); // R7

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_count != '0); // R9
endmodule

bind serial_ctrl_regs sreg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flag_set(flag_set),
  .flags(flag_q), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .rx_irq(rx_irq), .tx_irq(tx_irq),
  .rx_pop(rx_pop), .rx_count(rx_count)
);

// File: tb/serial_ctrl_regs_tb.sv
module serial_ctrl_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [5:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [4:0] flag_set = 0;
  logic tx_valid, tx_ready = 0;
  logic [7:0] tx_data, rx_data = 0;
  logic [CNT_W-1:0] rx_count = 0;
  logic rx_pop, rx_flush, tx_irq, rx_irq;
  logic [4:0] rx_trig_level;

  int n_run = 0, n_fail = 0;
  logic [7:0] rdv;
  logic popv, flushv;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_ctrl_regs #(.CNT_W(CNT_W)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus access; combinational outputs captured in the access cycle
  task automatic bus(input logic we, input logic [5:0] a, input logic [7:0] d,
                     input logic [4:0] hs);
    @(negedge clk);
    bus_en = 1; bus_we = we; bus_addr = a; bus_wdata = d; flag_set = hs;
    #1;
    rdv = bus_rdata; popv = rx_pop; flushv = rx_flush;
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0; flag_set = 0;
  endtask

  task automatic pulse(input logic [4:0] hs);
    @(negedge clk); flag_set = hs;
    @(posedge clk); #1; flag_set = 0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] e);
    bus(1'b0, a, 8'h00, 5'b0);
    chk(req, rdv, e);
  endtask

  // {write offset, write data, read offset, expected read}
  localparam logic [31:0] VEC [10] = '{
    {8'h00, 8'hFF, 8'h00, 8'h7B},  // R2 mode mask
    {8'h08, 8'hFF, 8'h08, 8'hFA},  // R2 control mask
    {8'h20, 8'hFF, 8'h20, 8'hF3},  // R2 port mask
    {8'h04, 8'h5A, 8'h04, 8'h5A},  // R2 bit-rate
    {8'h18, 8'hC0, 8'h18, 8'hC0},  // R2 FIFO control
    {8'h24, 8'hFF, 8'h24, 8'h00},  // R10 line status
    {8'h3C, 8'hAA, 8'h3C, 8'h00},  // R10 undefined
    {8'h10, 8'hFF, 8'h10, 8'h60},  // R3 ones keep
    {8'h10, 8'hBF, 8'h10, 8'h20},  // R3 clear transmit-done
    {8'h10, 8'h00, 8'h10, 8'h00}   // R3 clear all
  };

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd_chk("R1", 6'h00, 8'h00);
    rd_chk("R1", 6'h04, 8'hFF);
    rd_chk("R1", 6'h08, 8'h20);
    rd_chk("R1", 6'h10, 8'h60);
    rd_chk("R1", 6'h18, 8'h00);
    rd_chk("R1", 6'h20, 8'h00);
    chk("R1", {tx_valid, tx_irq, rx_irq}, 0);

    for (int i = 0; i < 10; i++) begin
      bus(1'b1, VEC[i][29:24], VEC[i][23:16], 5'b0);
      rd_chk("R2/R3/R10 table", VEC[i][13:8], VEC[i][7:0]);
    end

    // R5 transmit stream
    pulse(5'b01000);
    rd_chk("R4", 6'h10, 8'h20);
    bus(1'b1, 6'h0C, 8'h41, 5'b0);
    chk("R5 valid", tx_valid, 1);
    chk("R5 data", tx_data, 8'h41);
    rd_chk("R5 tde", 6'h10, 8'h00);
    @(negedge clk); @(negedge clk);
    chk("R5 hold", {tx_valid, tx_data}, {1'b1, 8'h41});
    bus(1'b1, 6'h0C, 8'h42, 5'b0);
    chk("R5 replace", tx_data, 8'h42);
    rd_chk("R5 readback", 6'h0C, 8'h42);
    @(negedge clk) tx_ready = 1;
    @(posedge clk); #1 tx_ready = 0;
    chk("R5 accept", tx_valid, 0);

    // R4 hardware set wins over clear
    bus(1'b1, 6'h10, 8'h00, 5'b00100);
    rd_chk("R4", 6'h10, 8'h10);
    pulse(5'b00001);
    rd_chk("R4", 6'h10, 8'h11);
    bus(1'b1, 6'h10, 8'hFE, 5'b0);
    rd_chk("R3", 6'h10, 8'h10);

    // R7 receive interrupt (control is 0xFA, bit 6 set)
    pulse(5'b00010);
    chk("R7 raise", rx_irq, 1);
    rd_chk("R7", 6'h10, 8'h12);
    bus(1'b1, 6'h10, 8'hFF, 5'b0);
    chk("R7 ones keep", rx_irq, 1);
    bus(1'b1, 6'h10, 8'hFD, 5'b0);
    chk("R7 drop", rx_irq, 0);
    rd_chk("R7", 6'h10, 8'h10);
    bus(1'b1, 6'h10, 8'hFC, 5'b00010);
    chk("R7 set wins", rx_irq, 1);
    rd_chk("R7", 6'h10, 8'h12);

    // R6 control side effects
    bus(1'b1, 6'h08, 8'hB0, 5'b0);
    chk("R6 rx drop", rx_irq, 0);
    chk("R6 tx_irq", tx_irq, 1);
    rd_chk("R6", 6'h08, 8'hB0);
    bus(1'b1, 6'h08, 8'h10, 5'b0);
    chk("R6 tx_irq low", tx_irq, 0);
    rd_chk("R6 tend", 6'h10, 8'h52);
    pulse(5'b00010);
    chk("R7 masked", rx_irq, 0);

    // R8 FIFO control
    bus(1'b1, 6'h18, 8'h42, 5'b0);
    chk("R8 flush", flushv, 1);
    chk("R8 trig4", rx_trig_level, 4);
    bus(1'b1, 6'h18, 8'h80, 5'b0);
    chk("R8 no flush", flushv, 0);
    chk("R8 trig8", rx_trig_level, 8);
    bus(1'b1, 6'h18, 8'h00, 5'b0);
    chk("R8 trig1", rx_trig_level, 1);
    bus(1'b1, 6'h18, 8'hC0, 5'b0);
    chk("R8 trig14", rx_trig_level, 14);

    // R9 receive read
    rx_data = 8'h5C;
    bus(1'b0, 6'h14, 8'h00, 5'b0);
    chk("R9 data", rdv, 8'h5C);
    chk("R9 empty no pop", popv, 0);
    rx_count = 3;
    bus(1'b0, 6'h14, 8'h00, 5'b0);
    chk("R9 pop", popv, 1);
    rd_chk("R9 count", 6'h1C, 8'h03);

    // R10 undefined offsets
    bus(1'b0, 6'h3C, 8'h00, 5'b0);
    chk("R10 read", rdv, 0);
    chk("R10 no pop", popv, 0);
    bus(1'b1, 6'h3C, 8'hFF, 5'b0);
    bus(1'b1, 6'h24, 8'h00, 5'b0);
    rd_chk("R10 stat", 6'h10, 8'h52);
    rd_chk("R10 ctrl", 6'h08, 8'h10);
    chk("R10 outs", {tx_valid, tx_irq, rx_irq}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule